// File: doc/BRIEF.md
# Serial Configuration Frame Checker

This block sits on the serial configuration input of a programmable device and breaks the incoming bit stream into frames. The stream arrives one bit per rising edge of the configuration clock. The block throws away a fixed-length lead-in and then hunts for a zero start bit. It collects a fixed number of payload bits and then takes three stop bits. Each completed payload leaves the block as a parallel word, tagged with the index of the frame it came from. A downstream loader writes those words into configuration storage.

Two framing disciplines are available, picked by a mode input.
- **Lenient mode:** the stop bits are accepted whatever their value. A damaged stream therefore still advances frame by frame and can reach completion with wrong contents.
- **Strict mode:** every stop bit must be a one. A zero in a stop position pulls the active-low status output low and freezes loading. The configuration clock keeps running, and only a reset can start a new load.

When the last stop bit of the final frame has been accepted, the block raises a sticky completion flag and ignores all further bits.

Top module: `cfg_frame_checker`

## Requirements
- R1: The first PREAMBLE_BITS bits after reset are consumed whatever their values, so no zero among them is taken as a start bit.
- R2: Once the lead-in or a frame's stop field is over, the next frame begins at the first 0 bit received. Any number of 1 bits before that zero are skipped.
- R3: The FRAME_BITS bits that follow a start bit are the payload. They are assembled MSB-first: the first payload bit received lands in bit FRAME_BITS-1 of `word_o`. The word is presented with `word_vld_o` high for exactly one cycle, in the cycle after the edge that samples the last payload bit.
- R4: The payload is followed by three stop bits. With `strict_i` = 0 their values are not inspected, so a frame with a bad stop field still completes and its word is still delivered.
- R5: With `strict_i` = 1, a 0 sampled in any stop-bit position drives `init_n_o` low from the cycle after that edge onward. A stop field of 111 leaves `init_n_o` high.
- R6: Once `init_n_o` is low, no further word is delivered and `done_o` never rises, whatever bits arrive, until reset.
- R7: `done_o` rises in the cycle after the edge that samples the third stop bit of frame NUM_FRAMES-1 and stays high until reset. After that, no further word is delivered.
- R8: While `rst` is high at a clock edge, the block returns to lead-in counting and clears the frame index. From the next cycle `init_n_o` = 1, `done_o` = 0 and `word_vld_o` = 0.
- R9: `word_idx_o` is 0 for the first frame after reset and grows by one for each following frame, up to NUM_FRAMES-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; one stream bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Serial configuration data |
| strict_i | input | 1 | 1 = stop bits must be ones, 0 = stop bits unchecked |
| word_o | output | FRAME_BITS | Assembled payload word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| word_idx_o | output | max(1,clog2(NUM_FRAMES)) | Frame index of the word on `word_o` |
| init_n_o | output | 1 | Active-low framing error flag |
| done_o | output | 1 | Sticky completion flag |

## Verification
The lead-in is driven in two forms: all zeros, and an alternating pattern. A first word that is correct shows that zeros inside the lead-in never open a frame. Frames are separated by runs of idle ones of different lengths, including none. Their payloads mix all-zero, all-one and uneven patterns, which separates a correct hunt for the start bit and correct MSB-first assembly from off-by-one and bit-reversal faults. The same stream with one zero in a stop field is sent once in strict mode and once in lenient mode: lock-up in the first case and full completion in the second show that the mode input alone decides the outcome. Bits sent after completion and after lock-up confirm that no stray word is produced.

// File: rtl/cfg_frame_pkg.sv
`timescale 1ns/1ps
package cfg_frame_pkg;
   localparam int STOP_BITS = 3;

   typedef enum logic [2:0] {
      ST_PRE  = 3'd0,
      ST_HUNT = 3'd1,
      ST_PAY  = 3'd2,
      ST_STOP = 3'd3,
      ST_DONE = 3'd4,
      ST_FAIL = 3'd5
   } cfg_state_e;
endpackage

// File: rtl/cfg_frame_ctrl.sv
`timescale 1ns/1ps
module cfg_frame_ctrl
   import cfg_frame_pkg::*;
#(
   parameter int PREAMBLE_BITS  = 40,
   parameter int FRAME_BITS     = 8,
   parameter int NUM_FRAMES     = 4,
   parameter bit STRICT_CAPABLE = 1'b1,
   localparam int CNT_MAX = (PREAMBLE_BITS > FRAME_BITS) ?
                            ((PREAMBLE_BITS > STOP_BITS) ? PREAMBLE_BITS : STOP_BITS) :
                            ((FRAME_BITS > STOP_BITS) ? FRAME_BITS : STOP_BITS),
   localparam int CW = $clog2(CNT_MAX + 1),
   localparam int IW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bit_i,
   input  logic          strict_i,
   output logic          shift_en_o,
   output logic          last_pay_o,
   output logic [IW-1:0] frame_idx_o,
   output logic          init_n_o,
   output logic          done_o
);
   localparam logic [CW-1:0] PRE_LAST  = CW'(PREAMBLE_BITS - 1);
   localparam logic [CW-1:0] PAY_LAST  = CW'(FRAME_BITS - 1);
   localparam logic [CW-1:0] STOP_LAST = CW'(STOP_BITS - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(NUM_FRAMES - 1);

   cfg_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [IW-1:0] fidx_q, fidx_d;
   logic          stop_bad;

   // Variant: the stop-bit check is built only when the strict mode is wanted.
   generate
      if (STRICT_CAPABLE) begin : g_strict
         assign stop_bad = strict_i & ~bit_i;
      end else begin : g_lenient_only
         assign stop_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      fidx_d  = fidx_q;
      unique case (state_q)
         ST_PRE: begin
            if (cnt_q == PRE_LAST) begin
               state_d = ST_HUNT;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_HUNT: begin
            if (!bit_i) begin
               state_d = ST_PAY;
               cnt_d   = '0;
            end
         end
         ST_PAY: begin
            if (cnt_q == PAY_LAST) begin
               state_d = ST_STOP;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_STOP: begin
            if (stop_bad) begin
               state_d = ST_FAIL;
            end else if (cnt_q == STOP_LAST) begin
               cnt_d = '0;
               if (fidx_q == IDX_LAST) begin
                  state_d = ST_DONE;
               end else begin
                  state_d = ST_HUNT;
                  fidx_d  = fidx_q + 1'b1;
               end
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_PRE;
         cnt_q   <= '0;
         fidx_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         fidx_q  <= fidx_d;
      end
   end

   assign shift_en_o  = (state_q == ST_PAY);
   assign last_pay_o  = (state_q == ST_PAY) && (cnt_q == PAY_LAST);
   assign frame_idx_o = fidx_q;
   assign init_n_o    = (state_q != ST_FAIL);
   assign done_o      = (state_q == ST_DONE);

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o);

   assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      !init_n_o |=> (!init_n_o && !done_o));

   assert_no_load_after_end_R6: assert property (@(posedge clk) disable iff (rst)
      (done_o || !init_n_o) |=> !shift_en_o);

   generate
      if (STRICT_CAPABLE) begin : g_strict_chk
         assert_bad_stop_flags_R5: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_STOP && strict_i && !bit_i) |=> !init_n_o);
      end
   endgenerate
endmodule

// File: rtl/cfg_payload_sreg.sv
`timescale 1ns/1ps
module cfg_payload_sreg #(
   parameter int FRAME_BITS = 8,
   parameter int IW         = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  shift_en_i,
   input  logic                  last_i,
   input  logic                  bit_i,
   input  logic [IW-1:0]         idx_i,
   output logic [FRAME_BITS-1:0] word_o,
   output logic                  word_vld_o,
   output logic [IW-1:0]         word_idx_o
);
   logic [FRAME_BITS-1:0] assembled;

   // Variant: a one-bit frame needs no history register.
   generate
      if (FRAME_BITS == 1) begin : g_single
         assign assembled = bit_i;
      end else begin : g_multi
         logic [FRAME_BITS-2:0] hist_q;
         assign assembled = {hist_q, bit_i};
         always_ff @(posedge clk) begin
            if (rst)             hist_q <= '0;
            else if (shift_en_i) hist_q <= assembled[FRAME_BITS-2:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         word_o     <= '0;
         word_vld_o <= 1'b0;
         word_idx_o <= '0;
      end else begin
         word_vld_o <= last_i;
         if (last_i) begin
            word_o     <= assembled;
            word_idx_o <= idx_i;
         end
      end
   end

   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/cfg_frame_checker.sv
`timescale 1ns/1ps
module cfg_frame_checker #(
   parameter int PREAMBLE_BITS  = 40,
   parameter int FRAME_BITS     = 8,
   parameter int NUM_FRAMES     = 4,
   parameter bit STRICT_CAPABLE = 1'b1,
   localparam int IW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bit_i,
   input  logic                  strict_i,
   output logic [FRAME_BITS-1:0] word_o,
   output logic                  word_vld_o,
   output logic [IW-1:0]         word_idx_o,
   output logic                  init_n_o,
   output logic                  done_o
);
   generate
      if (PREAMBLE_BITS < 1) begin : g_bad_pre
         $error("PREAMBLE_BITS must be at least 1");
      end
      if (FRAME_BITS < 1) begin : g_bad_frame
         $error("FRAME_BITS must be at least 1");
      end
      if (NUM_FRAMES < 1) begin : g_bad_count
         $error("NUM_FRAMES must be at least 1");
      end
   endgenerate

   logic          shift_en;
   logic          last_pay;
   logic [IW-1:0] frame_idx;

   cfg_frame_ctrl #(
      .PREAMBLE_BITS (PREAMBLE_BITS),
      .FRAME_BITS    (FRAME_BITS),
      .NUM_FRAMES    (NUM_FRAMES),
      .STRICT_CAPABLE(STRICT_CAPABLE)
   ) ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .bit_i      (bit_i),
      .strict_i   (strict_i),
      .shift_en_o (shift_en),
      .last_pay_o (last_pay),
      .frame_idx_o(frame_idx),
      .init_n_o   (init_n_o),
      .done_o     (done_o)
   );

   cfg_payload_sreg #(
      .FRAME_BITS(FRAME_BITS),
      .IW        (IW)
   ) sreg_i (
      .clk       (clk),
      .rst       (rst),
      .shift_en_i(shift_en),
      .last_i    (last_pay),
      .bit_i     (bit_i),
      .idx_i     (frame_idx),
      .word_o    (word_o),
      .word_vld_o(word_vld_o),
      .word_idx_o(word_idx_o)
   );

   assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (rst)
      word_vld_o |-> (int'(word_idx_o) < NUM_FRAMES));

   assert_no_word_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !word_vld_o);
endmodule

// File: tb/cfg_frame_checker_tb_top.sv
`timescale 1ns/1ps
module cfg_frame_checker_tb_top;
   localparam int PB = 40;
   localparam int FB = 8;
   localparam int NF = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bit_in = 1'b1;
   logic          strict = 1'b0;
   logic [FB-1:0] word;
   logic          word_vld;
   logic [IW-1:0] word_idx;
   logic          init_n;
   logic          done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [IW+FB-1:0] exp_q[$];

   always #2 clk = ~clk;

   cfg_frame_checker #(
      .PREAMBLE_BITS(PB), .FRAME_BITS(FB), .NUM_FRAMES(NF), .STRICT_CAPABLE(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .bit_i(bit_in), .strict_i(strict),
      .word_o(word), .word_vld_o(word_vld), .word_idx_o(word_idx),
      .init_n_o(init_n), .done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: compares every word strobe with the scoreboard queue (R3, R9).
   always @(negedge clk) begin
      if (!rst && word_vld) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3/R6/R7 unexpected word", int'({word_idx, word}), 0);
         end else begin
            logic [IW+FB-1:0] e;
            e = exp_q.pop_front();
            check({word_idx, word} == e, "R3/R9 word+index", int'({word_idx, word}), int'(e));
         end
      end
   end

   // Driver: the bit is applied at a falling edge, sampled at the next rising edge,
   // and the task returns at the falling edge after, where outputs are settled.
   task automatic send_bit(input logic b);
      bit_in = b;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      bit_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send_preamble(input bit alternate);
      for (int i = 0; i < PB; i++) send_bit(alternate ? logic'(i % 2) : 1'b0);
   endtask

   task automatic send_frame(input int idx, input logic [FB-1:0] w, input int gap, input bit expect_word);
      for (int i = 0; i < gap; i++) send_bit(1'b1);
      send_bit(1'b0);
      if (expect_word) exp_q.push_back({IW'(idx), w});
      for (int i = FB - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic send_stop(input logic [2:0] s);
      for (int i = 2; i >= 0; i--) send_bit(s[i]);
   endtask

   logic [FB-1:0] pay [NF];
   int            gaps[NF];

   initial begin
      pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF; pay[3] = 8'h3C;
      gaps[0] = 0; gaps[1] = 2; gaps[2] = 5; gaps[3] = 1;
      @(negedge clk);
      do_reset();
      // R8: reset state
      check(init_n === 1'b1, "R8 init_n after reset", int'(init_n), 1);
      check(done === 1'b0, "R8 done after reset", int'(done), 0);
      check(word_vld === 1'b0, "R8 word_vld after reset", int'(word_vld), 0);

      // Lenient, all-zero lead-in (R1), varied gaps (R2), done timing (R7)
      strict = 1'b0;
      send_preamble(1'b0);
      for (int f = 0; f < NF; f++) begin
         send_frame(f, pay[f], gaps[f], 1'b1);
         if (f == NF - 1) begin
            send_bit(1'b1); send_bit(1'b1);
            check(done === 1'b0, "R7 done early", int'(done), 0);
            send_bit(1'b1);
         end else begin
            send_stop(3'b111);
         end
      end
      check(done === 1'b1, "R7 done after last stop", int'(done), 1);
      check(exp_q.size() == 0, "R1/R2 all words seen", exp_q.size(), 0);
      for (int i = 0; i < 2 * (FB + 4); i++) send_bit(logic'(i % 3 == 0));
      check(done === 1'b1, "R7 done sticky", int'(done), 1);
      check(init_n === 1'b1, "R4 init_n lenient", int'(init_n), 1);

      // Strict, good stream, alternating lead-in (R5 not triggered)
      do_reset();
      check(done === 1'b0, "R8 done cleared", int'(done), 0);
      strict = 1'b1;
      send_preamble(1'b1);
      for (int f = 0; f < NF; f++) begin
         send_frame(f, ~pay[f], gaps[NF - 1 - f], 1'b1);
         send_stop(3'b111);
      end
      check(done === 1'b1, "R5 strict good done", int'(done), 1);
      check(init_n === 1'b1, "R5 strict good init_n", int'(init_n), 1);

      // Strict, bad stop field in frame 1 (R5, R6)
      do_reset();
      strict = 1'b1;
      send_preamble(1'b0);
      send_frame(0, pay[0], 0, 1'b1);
      send_stop(3'b111);
      send_frame(1, pay[1], 1, 1'b1);
      send_bit(1'b1);
      check(init_n === 1'b1, "R5 init_n before bad bit", int'(init_n), 1);
      send_bit(1'b0);
      check(init_n === 1'b0, "R5 init_n after bad bit", int'(init_n), 0);
      send_bit(1'b1);
      for (int f = 2; f < NF; f++) begin
         send_frame(f, pay[f], 0, 1'b0);
         send_stop(3'b111);
      end
      check(init_n === 1'b0, "R6 init_n stays low", int'(init_n), 0);
      check(done === 1'b0, "R6 done never rises", int'(done), 0);
      check(exp_q.size() == 0, "R6 no stray words", exp_q.size(), 0);

      // Reset clears failure (R8), lenient with the same bad stream (R4)
      do_reset();
      check(init_n === 1'b1, "R8 init_n released", int'(init_n), 1);
      strict = 1'b0;
      send_preamble(1'b1);
      for (int f = 0; f < NF; f++) begin
         send_frame(f, pay[f] ^ 8'h81, 1, 1'b1);
         send_stop(f == 1 ? 3'b101 : 3'b111);
      end
      check(done === 1'b1, "R4 lenient bad stop reaches done", int'(done), 1);
      check(init_n === 1'b1, "R4 lenient init_n high", int'(init_n), 1);
      check(exp_q.size() == 0, "R4/R9 all words seen", exp_q.size(), 0);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule